// File: doc/BRIEF.md
# TDM Time Slot Channel Selector

This block sits on a serial time-division-multiplexed bus and pulls one subscriber channel out of every frame. It also puts the outgoing bits for that channel onto the transmit line. A single slot register chooses the channel. A mode input and a rate input decide how that register is read, which gives four ways of placing the channel. In plain multiplex mode the channel can be one of 64 byte slots or one of 256 two-bit slots. In GCI framing the frame is split into channels of four bytes each. At the fast rate the channel is B1 or B2 of one GCI channel. At the slow rate it is the two-bit D field of one GCI channel.

Bit clock, frame sync and serial data are all synchronous to the system clock, and the block finds the clock edges by oversampling. Receive bits are taken on falling bit-clock edges. Transmit bits change on rising bit-clock edges. Slot, mode and rate are loaded into the block only when frame sync is seen. Software can therefore rewrite them at any point in a frame and the frame in progress is not disturbed. Each captured channel value is presented with a one-cycle strobe.

Top module: `tdm_slot_sel`

## Requirements
- R1: After reset `rx_valid` is 0, `tx_oe` is 0 and `txd` is 1. Until the first frame sync has been seen, no strobe is raised and the transmit line is never enabled.
- R2: Frame sync sampled on a rising bit-clock edge makes that bit position 0 of the frame. Each later rising edge advances the position by one. After position 511 the position wraps to 0, even when no new frame sync arrives.
- R3: With `gci_mode`=0 and `rate64`=1, the channel is the 8 bits that start at position `slot_sel[7:2]`*8. `slot_sel[1:0]` are ignored. The first bit received lands in `rx_data[7]`.
- R4: With `gci_mode`=0 and `rate64`=0, the channel is the 2 bits that start at position `slot_sel`*2. `rx_data[1]` holds the first bit, `rx_data[0]` holds the second, and `rx_data[7:2]` are 0.
- R5: With `gci_mode`=1 and `rate64`=1, GCI channel `slot_sel[7:4]` occupies positions `slot_sel[7:4]`*32 to `slot_sel[7:4]`*32+31. `slot_sel[2]`=0 picks its first byte (B1) and `slot_sel[2]`=1 picks its second byte (B2). The byte is packed as in R3.
- R6: With `gci_mode`=1 and `rate64`=0, the channel is the first two bits of the fourth byte of GCI channel `slot_sel[7:4]`, at position `slot_sel[7:4]`*32+24. It is packed as in R4.
- R7: `rx_data` is updated and `rx_valid` is high for exactly one clock cycle. This happens right after the falling bit-clock edge that samples the last bit of the channel.
- R8: During every bit of the channel, `tx_oe` is 1 and `txd` carries `tx_byte`, most significant bit first. An 8-bit channel sends all of `tx_byte`. A 2-bit channel sends `tx_byte[1]` and then `tx_byte[0]`. `txd` and `tx_oe` change only just after a rising bit-clock edge.
- R9: Outside the channel, `tx_oe` is 0 and `txd` is held at 1.
- R10: A change to `slot_sel`, `gci_mode` or `rate64` has no effect on the frame in progress. It takes effect from the next frame sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bus bit clock, synchronous to `clk` |
| fsync | input | 1 | Frame sync, sampled on rising `bclk` |
| rxd | input | 1 | Serial receive data, sampled on falling `bclk` |
| gci_mode | input | 1 | 1: GCI framing, 0: plain multiplex |
| rate64 | input | 1 | 1: 8-bit channel, 0: 2-bit channel |
| slot_sel | input | SLOT_W | Slot register |
| tx_byte | input | BYTE_W | Data sent in the channel |
| rx_data | output | BYTE_W | Last captured channel value |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| txd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable |

## Verification
A frame position counter that is off by some amount shows up in two places. The wrong bits come out on the very next `rx_valid` strobe, and `tx_oe` opens at the wrong position within the same frame. The scoreboard compares every strobe, and it checks `txd`/`tx_oe` at every bit of every frame, so such a fault is caught within one frame. A configuration that is loaded at the wrong moment is caught in the frame where the configuration is changed halfway through. An edge detector that fires on the wrong polarity moves the capture by half a bit. That breaks the timing properties on the first strobe or on the first transmit change.

// File: rtl/tss_pkg.sv
package tss_pkg;

   // Mode and rate together pick one of four ways to read the slot register.
   typedef enum logic [1:0] {
      SEL_MUX_NARROW = 2'b00,
      SEL_MUX_WIDE   = 2'b01,
      SEL_GCI_D      = 2'b10,
      SEL_GCI_B      = 2'b11
   } sel_mode_e;

   function automatic sel_mode_e mode_of(input logic gci, input logic wide);
      return sel_mode_e'({gci, wide});
   endfunction

endpackage

// File: rtl/tss_frame_timer.sv
module tss_frame_timer #(
   parameter int SLOT_W     = 8,
   parameter int FRAME_BITS = 512,
   localparam int POS_W     = $clog2(FRAME_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              fsync,
   input  logic              gci_in,
   input  logic              r64_in,
   input  logic [SLOT_W-1:0] slot_in,
   output logic              rise,
   output logic              fall,
   output logic [POS_W-1:0]  pos_q,
   output logic [POS_W-1:0]  pos_nx,
   output logic              gci_q,
   output logic              r64_q,
   output logic [SLOT_W-1:0] slot_q,
   output logic              gci_nx,
   output logic              r64_nx,
   output logic [SLOT_W-1:0] slot_nx,
   output logic              sync_q,
   output logic              sync_nx
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

   logic bclk_q;

   assign rise = bclk & ~bclk_q;
   assign fall = ~bclk & bclk_q;

   // Position and configuration seen by the bit that starts at this rising edge.
   always_comb begin
      if (fsync)                 pos_nx = '0;
      else if (pos_q == LAST_POS) pos_nx = '0;
      else                       pos_nx = pos_q + POS_W'(1);
      gci_nx  = fsync ? gci_in  : gci_q;
      r64_nx  = fsync ? r64_in  : r64_q;
      slot_nx = fsync ? slot_in : slot_q;
      sync_nx = sync_q | fsync;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         pos_q  <= LAST_POS;
         gci_q  <= 1'b0;
         r64_q  <= 1'b0;
         slot_q <= '0;
         sync_q <= 1'b0;
      end else begin
         bclk_q <= bclk;
         if (rise) begin
            pos_q  <= pos_nx;
            gci_q  <= gci_nx;
            r64_q  <= r64_nx;
            slot_q <= slot_nx;
            sync_q <= sync_nx;
         end
      end
   end

endmodule

// File: rtl/tss_window.sv
module tss_window
   import tss_pkg::*;
#(
   parameter int SLOT_W     = 8,
   parameter int BYTE_W     = 8,
   parameter int NARROW_W   = 2,
   parameter int FRAME_BITS = 512,
   localparam int POS_W     = $clog2(FRAME_BITS),
   localparam int IDX_W     = $clog2(BYTE_W),
   localparam int AW        = POS_W + 1
) (
   input  logic              gci,
   input  logic              r64,
   input  logic [SLOT_W-1:0] slot,
   input  logic [POS_W-1:0]  pos,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output logic              wide
);

   localparam int CH_BITS = 4 * BYTE_W;

   logic [AW-1:0] start;
   logic [AW-1:0] len;
   logic [AW-1:0] off;
   logic [AW-1:0] ch_base;

   always_comb begin
      ch_base = AW'(slot[SLOT_W-1:SLOT_W-4]) * AW'(CH_BITS);
      unique case (mode_of(gci, r64))
         SEL_MUX_WIDE:   start = AW'(slot[SLOT_W-1:2]) * AW'(BYTE_W);
         SEL_MUX_NARROW: start = AW'(slot) * AW'(NARROW_W);
         SEL_GCI_B:      start = ch_base + (slot[2] ? AW'(BYTE_W) : '0);
         SEL_GCI_D:      start = ch_base + AW'(3 * BYTE_W);
         default:        start = '0;
      endcase
      wide = r64;
      len  = r64 ? AW'(BYTE_W) : AW'(NARROW_W);
      off  = {1'b0, pos} - start;
      hit  = ({1'b0, pos} >= start) && (off < len);
      idx  = off[IDX_W-1:0];
   end

endmodule

// File: rtl/tss_rx_capture.sv
module tss_rx_capture #(
   parameter int BYTE_W   = 8,
   parameter int NARROW_W = 2,
   localparam int IDX_W   = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  logic              synced,
   input  logic              hit,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wide,
   input  logic              rxd,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid
);

   localparam logic [IDX_W-1:0] LAST_W = IDX_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0] LAST_N = IDX_W'(NARROW_W - 1);

   logic [BYTE_W-2:0] sreg;
   logic [BYTE_W-1:0] full;
   logic [BYTE_W-1:0] fmt;
   logic              take;
   logic              last;

   assign full = {sreg, rxd};
   assign take = fall & synced & hit;
   assign last = (idx == (wide ? LAST_W : LAST_N));

   // Narrow channels keep only the low bits; the upper ones read as zero.
   for (genvar i = 0; i < BYTE_W; i++) begin : g_fmt
      if (i < NARROW_W) begin : g_low
         assign fmt[i] = full[i];
      end else begin : g_high
         assign fmt[i] = wide & full[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg     <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (take) begin
            if (idx == '0) sreg <= {{(BYTE_W-2){1'b0}}, rxd};
            else           sreg <= full[BYTE_W-2:0];
            if (last) begin
               rx_data  <= fmt;
               rx_valid <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tss_tx_drive.sv
module tss_tx_drive #(
   parameter int BYTE_W   = 8,
   parameter int NARROW_W = 2,
   localparam int IDX_W   = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              synced,
   input  logic              hit,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wide,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              txd,
   output logic              tx_oe
);

   localparam logic [IDX_W-1:0] TOP_W = IDX_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0] TOP_N = IDX_W'(NARROW_W - 1);

   logic [IDX_W-1:0] sel;

   assign sel = (wide ? TOP_W : TOP_N) - idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txd   <= 1'b1;
         tx_oe <= 1'b0;
      end else if (rise) begin
         if (synced && hit) begin
            txd   <= tx_byte[sel];
            tx_oe <= 1'b1;
         end else begin
            txd   <= 1'b1;
            tx_oe <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tdm_slot_sel.sv
module tdm_slot_sel #(
   parameter int SLOT_W   = 8,
   parameter int BYTE_W   = 8,
   parameter int NARROW_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              fsync,
   input  logic              rxd,
   input  logic              gci_mode,
   input  logic              rate64,
   input  logic [SLOT_W-1:0] slot_sel,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              txd,
   output logic              tx_oe
);

   localparam int FRAME_BITS = (2 ** SLOT_W) * NARROW_W;
   localparam int POS_W      = $clog2(FRAME_BITS);
   localparam int IDX_W      = $clog2(BYTE_W);

   // Every reading of the slot register must span exactly one frame.
   if (BYTE_W != 4 * NARROW_W) begin : g_bad_ratio
      $error("BYTE_W must equal four times NARROW_W");
   end
   if (SLOT_W < 7) begin : g_bad_slot
      $error("SLOT_W must be at least 7");
   end
   if (NARROW_W < 2) begin : g_bad_narrow
      $error("NARROW_W must be at least 2");
   end

   logic              rise, fall;
   logic [POS_W-1:0]  pos_q, pos_nx;
   logic              gci_q, r64_q, gci_nx, r64_nx;
   logic [SLOT_W-1:0] slot_q, slot_nx;
   logic              sync_q, sync_nx;
   logic              rx_hit, tx_hit, rx_wide, tx_wide;
   logic [IDX_W-1:0]  rx_idx, tx_idx;

   tss_frame_timer #(.SLOT_W(SLOT_W), .FRAME_BITS(FRAME_BITS)) u_timer (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
      .gci_in(gci_mode), .r64_in(rate64), .slot_in(slot_sel),
      .rise(rise), .fall(fall), .pos_q(pos_q), .pos_nx(pos_nx),
      .gci_q(gci_q), .r64_q(r64_q), .slot_q(slot_q),
      .gci_nx(gci_nx), .r64_nx(r64_nx), .slot_nx(slot_nx),
      .sync_q(sync_q), .sync_nx(sync_nx)
   );

   // Receive side decodes the registered position; transmit side looks one bit ahead.
   tss_window #(.SLOT_W(SLOT_W), .BYTE_W(BYTE_W), .NARROW_W(NARROW_W),
                .FRAME_BITS(FRAME_BITS)) u_rx_win (
      .gci(gci_q), .r64(r64_q), .slot(slot_q), .pos(pos_q),
      .hit(rx_hit), .idx(rx_idx), .wide(rx_wide)
   );

   tss_window #(.SLOT_W(SLOT_W), .BYTE_W(BYTE_W), .NARROW_W(NARROW_W),
                .FRAME_BITS(FRAME_BITS)) u_tx_win (
      .gci(gci_nx), .r64(r64_nx), .slot(slot_nx), .pos(pos_nx),
      .hit(tx_hit), .idx(tx_idx), .wide(tx_wide)
   );

   tss_rx_capture #(.BYTE_W(BYTE_W), .NARROW_W(NARROW_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .fall(fall), .synced(sync_q),
      .hit(rx_hit), .idx(rx_idx), .wide(rx_wide), .rxd(rxd),
      .rx_data(rx_data), .rx_valid(rx_valid)
   );

   tss_tx_drive #(.BYTE_W(BYTE_W), .NARROW_W(NARROW_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .rise(rise), .synced(sync_nx),
      .hit(tx_hit), .idx(tx_idx), .wide(tx_wide), .tx_byte(tx_byte),
      .txd(txd), .tx_oe(tx_oe)
   );

endmodule

// File: rtl/tdm_slot_sel_chk.sv
module tdm_slot_sel_chk (
   input logic clk,
   input logic rst_n,
   input logic bclk,
   input logic fsync,
   input logic rx_valid,
   input logic txd,
   input logic tx_oe
);

   logic bq;
   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bq   <= 1'b0;
         seen <= 1'b0;
      end else begin
         bq <= bclk;
         if (bclk && !bq && fsync) seen <= 1'b1;
      end
   end

   // R1: nothing leaves the block before the first frame sync
   p_quiet_until_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (!tx_oe && !rx_valid));

   // R7: strobe lasts exactly one cycle
   p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R7: strobe follows a falling bit-clock edge
   p_valid_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (!$past(bclk) && $past(bq)));

   // R8: transmit outputs move only after a rising bit-clock edge
   p_tx_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(txd) || !$stable(tx_oe)) |-> ($past(bclk) && !$past(bq)));

   // R9: idle line is high
   p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> txd);

endmodule

bind tdm_slot_sel tdm_slot_sel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
   .rx_valid(rx_valid), .txd(txd), .tx_oe(tx_oe)
);

// File: tb/sim_tdm_slot_sel.sv
`timescale 1ns/1ps
module sim_tdm_slot_sel;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bclk = 1'b0;
   logic       fsync = 1'b0;
   logic       rxd = 1'b1;
   logic       gci_mode = 1'b0;
   logic       rate64 = 1'b0;
   logic [7:0] slot_sel = 8'h00;
   logic [7:0] tx_byte = 8'h00;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       txd;
   logic       tx_oe;

   int total = 0;
   int bad = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   // model state
   logic       m_sync = 1'b0;
   int         m_pos = 511;
   logic       e_gci = 1'b0, e_r64 = 1'b0;
   logic [7:0] e_slot = 8'h00;
   logic [7:0] m_val = 8'h00;

   always #2.5 clk = ~clk;

   tdm_slot_sel u0 (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rxd(rxd),
      .gci_mode(gci_mode), .rate64(rate64), .slot_sel(slot_sel),
      .tx_byte(tx_byte), .rx_data(rx_data), .rx_valid(rx_valid),
      .txd(txd), .tx_oe(tx_oe)
   );

   function automatic logic pat(input int f, input int b);
      int v;
      v = (b * 37 + f * 101) ^ (b >> 3);
      return v[0] ^ v[3] ^ v[5];
   endfunction

   function automatic void model_win(input logic g, input logic r, input logic [7:0] s,
                                     output int st, output int ln);
      ln = r ? 8 : 2;
      if (!g) st = r ? int'(s[7:2]) * 8 : int'(s) * 2;
      else    st = int'(s[7:4]) * 32 + (r ? (s[2] ? 8 : 0) : 24);
   endfunction

   // monitor: pops expected values as strobes appear
   logic prev_v = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_v) begin
            total++;
            if (rx_valid) begin
               bad++;
               $display("FAIL R7 strobe width got 2+ cycles exp 1");
            end
         end
         if (rx_valid) begin
            total++;
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL R1 unexpected rx_valid got %h exp none", rx_data);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (rx_data !== e) begin
                  bad++;
                  $display("FAIL %s rx_data got %h exp %h", t, rx_data, e);
               end
            end
         end
         prev_v = rx_valid;
      end
   end

   task automatic run_frame(input int f, input bit sync,
                            input logic n_g, input logic n_r, input logic [7:0] n_s,
                            input int chg_at,
                            input logic c_g, input logic c_r, input logic [7:0] c_s,
                            input logic [7:0] tb, input string tag);
      int st, ln, errs, first_b;
      logic got_oe, got_txd, want_oe, want_txd;
      errs = 0;
      first_b = -1;
      got_oe = 1'b0; got_txd = 1'b0; want_oe = 1'b0; want_txd = 1'b0;
      gci_mode = n_g; rate64 = n_r; slot_sel = n_s; tx_byte = tb;
      for (int b = 0; b < 512; b++) begin
         logic bitv, inw;
         if (b == chg_at) begin
            gci_mode = c_g; rate64 = c_r; slot_sel = c_s;
         end
         bitv = pat(f, b);
         if (sync && b == 0) begin
            m_pos = 0; m_sync = 1'b1;
            e_gci = gci_mode; e_r64 = rate64; e_slot = slot_sel;
         end else begin
            m_pos = (m_pos + 1) % 512;
         end
         model_win(e_gci, e_r64, e_slot, st, ln);
         inw = m_sync && (m_pos >= st) && (m_pos < st + ln);
         @(negedge clk);
         bclk = 1'b1; fsync = sync && (b == 0); rxd = bitv;
         if (inw) begin
            m_val = (m_pos == st) ? {7'b0, bitv} : {m_val[6:0], bitv};
            if (m_pos == st + ln - 1) begin
               exp_q.push_back(m_val);
               tag_q.push_back(tag);
            end
         end
         repeat (3) @(negedge clk);
         want_oe  = inw;
         want_txd = inw ? tb[ln - 1 - (m_pos - st)] : 1'b1;
         if (tx_oe !== want_oe || txd !== want_txd) begin
            if (errs == 0) begin
               first_b = b; got_oe = tx_oe; got_txd = txd;
            end
            errs++;
         end
         @(negedge clk);
         bclk = 1'b0;
         repeat (3) @(negedge clk);
      end
      total++;
      if (errs != 0) begin
         bad++;
         $display("FAIL R8 R9 %s tx at bit %0d got oe=%b txd=%b exp oe=%b txd=%b",
                  tag, first_b, got_oe, got_txd, want_oe, want_txd);
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      total++;
      if (rx_valid !== 1'b0 || tx_oe !== 1'b0 || txd !== 1'b1) begin
         bad++;
         $display("FAIL R1 reset got v=%b oe=%b txd=%b exp 0 0 1", rx_valid, tx_oe, txd);
      end
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1: no sync yet, nothing may appear
      run_frame(1, 0, 0, 1, 8'h14, -1, 0, 0, 8'h00, 8'hA6, "R1");
      // R3: byte slots, including first and last and ignored low bits
      run_frame(2, 1, 0, 1, 8'h14, -1, 0, 0, 8'h00, 8'hA6, "R3");
      run_frame(3, 1, 0, 1, 8'h00, -1, 0, 0, 8'h00, 8'h5A, "R3");
      run_frame(4, 1, 0, 1, 8'hFF, -1, 0, 0, 8'h00, 8'hC3, "R3");
      // R4: two-bit slots
      run_frame(5, 1, 0, 0, 8'h00, -1, 0, 0, 8'h00, 8'h02, "R4");
      run_frame(6, 1, 0, 0, 8'hFF, -1, 0, 0, 8'h00, 8'h01, "R4");
      run_frame(7, 1, 0, 0, 8'h37, -1, 0, 0, 8'h00, 8'hFE, "R4");
      // R5: GCI B1/B2
      run_frame(8, 1, 1, 1, 8'h50, -1, 0, 0, 8'h00, 8'h3C, "R5");
      run_frame(9, 1, 1, 1, 8'h54, -1, 0, 0, 8'h00, 8'h96, "R5");
      run_frame(10, 1, 1, 1, 8'hF4, -1, 0, 0, 8'h00, 8'h81, "R5");
      // R6: GCI D field
      run_frame(11, 1, 1, 0, 8'h30, -1, 0, 0, 8'h00, 8'h01, "R6");
      run_frame(12, 1, 1, 0, 8'hF0, -1, 0, 0, 8'h00, 8'h02, "R6");
      // R2: no sync, the position wraps on its own
      run_frame(13, 0, 1, 0, 8'hF0, -1, 0, 0, 8'h00, 8'h02, "R2");
      // R10: mid-frame change ignored until the next sync
      run_frame(14, 1, 0, 0, 8'h37, 40, 0, 1, 8'h08, 8'h7E, "R10");
      run_frame(15, 1, 0, 1, 8'h08, -1, 0, 0, 8'h00, 8'h7E, "R10");
      repeat (20) @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R7 missing strobes got %0d left exp 0", exp_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog got timeout exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule